// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date. Every field is held as packed BCD: seconds, minutes, hours, date, month, two-digit year and a century byte. A day-of-week field is held as a small binary count. A one-cycle enable arrives once per second and advances the seconds. Each higher field moves only when everything below it rolls over on that same enable. The date rollover follows the length of the current month, and February gains its 29th day in leap years.

A host sets the clock through a small write port. It supplies a 3-bit field selector and a data byte, and the byte replaces the selected field on the next clock edge. All fields are driven on their own output ports at all times, so the host can read them directly with no read strobe.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs are: seconds, minutes, hours, year and day of week 00h; date 01h; month 01h; century 20h.
- R2: Each cycle with `tick_1hz` high, seconds step through BCD 00..59 and wrap to 00. In a cycle with neither a tick nor a write, no output changes.
- R3: Minutes (BCD 00..59) advance only when seconds wrap. Hours advance only when minutes wrap, counting BCD 00..23 in bits 5:0. Bit 7 of the hour byte is a 24-hour-mode flag: it is set only by a write and counting keeps it.
- R4: Date counts from BCD 01 up to the last day of the current month, then wraps to 01. April, June, September and November end on 30. February is covered by R5. Every other month ends on 31.
- R5: February ends on 29 when the BCD year is a multiple of 4 (00 included), and on 28 otherwise.
- R6: Month counts BCD 01..12 and advances when the date wraps. Year counts BCD 00..99 and advances when the month wraps from 12 to 01.
- R7: Day of week counts 0..6 in bits 2:0, with the upper bits zero. It advances each time the date advances, and wraps from 6 to 0.
- R8: When the year wraps from 99 to 00, a century byte of 19h becomes 20h. Any other century value stays unchanged.
- R9: A write with `wr_en` high stores `wr_data` into the field picked by `wr_field` on the next edge. The selector codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 century. A write takes priority over a tick for the written field. The other fields still follow the tick, with carries worked out from the values held before the edge.
- R10: All eight fields are driven on their output ports at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| wr_en | input | 1 | Host write strobe |
| wr_field | input | 3 | Field selector for the write |
| wr_data | input | 8 | Value written to the selected field |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Mode flag in bit 7, hours BCD in bits 5:0 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within the century, BCD |
| dow_o | output | 8 | Day of week, binary 0..6 |
| cent_o | output | 8 | Century, BCD |

## Verification
The range assertions rely on the host writing only legal BCD values inside each field's range. Without that guarantee the date could hold 00 or the day of week could exceed 6. The bench writes only such values, and it always places a date that is valid for the month and year already loaded. The carry and hold assertions rely on `tick_1hz` being a single-cycle strobe. The bench raises it for one cycle at a time, even when it is used on back-to-back cycles.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    F_SEC   = 3'd0,
    F_MIN   = 3'd1,
    F_HOUR  = 3'd2,
    F_DATE  = 3'd3,
    F_MONTH = 3'd4,
    F_YEAR  = 3'd5,
    F_DOW   = 3'd6,
    F_CENT  = 3'd7
  } field_e;

  // next BCD value, two digits
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of 4 in BCD: even tens need units 0/4/8, odd tens need 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] month, input logic [7:0] year);
    case (month)
      8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MIN_VAL   = 8'h00,
  parameter logic [7:0] RST_VAL   = 8'h00,
  parameter logic [7:0] KEEP_MASK = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic [7:0] top_val,
  output logic [7:0] value,
  output logic       wrap
);
  import rtc_cal_pkg::*;

  localparam logic [7:0] CNT_MASK = ~KEEP_MASK;

  logic [7:0] cnt;
  logic [7:0] cnt_next;

  assign cnt      = value & CNT_MASK;
  assign wrap     = step && (cnt >= top_val);
  assign cnt_next = wrap ? MIN_VAL : bcd_inc(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= RST_VAL;
    else if (load) value <= load_val;
    else if (step) value <= (value & KEEP_MASK) | (cnt_next & CNT_MASK);
  end

  // wrap always returns the count to its lowest value (R2, R3, R4, R6)
  p_wrap_to_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !load |=> (value & CNT_MASK) == MIN_VAL);

  // flag bits are untouched by counting (R3)
  p_keep_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> (value & KEEP_MASK) == ($past(value) & KEEP_MASK));

endmodule

// File: rtl/rtc_dow.sv
module rtc_dow #(
  parameter int unsigned DAYS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] value
);
  localparam int unsigned W = $clog2(DAYS);
  localparam logic [W-1:0] LAST = W'(DAYS - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val[W-1:0];
    else if (step)   cnt <= (cnt >= LAST) ? '0 : cnt + W'(1);
  end

  assign value = {{(8-W){1'b0}}, cnt};

  // R7: wrap from last day to zero
  p_dow_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && cnt == LAST |=> cnt == '0);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int unsigned DOW_DAYS = 7,
  parameter logic [7:0]  CENT_OLD = 8'h19,
  parameter logic [7:0]  CENT_NEW = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] dow_o,
  output logic [7:0] cent_o
);
  import rtc_cal_pkg::*;

  localparam int unsigned NUM_MS = 2;

  field_e sel;
  assign sel = field_e'(wr_field);

  logic [7:0] ld;
  always_comb begin
    ld = '0;
    if (wr_en) ld[wr_field] = 1'b1;
  end

  // named internal events
  logic [NUM_MS:0]   ms_step;
  logic [NUM_MS-1:0] ms_wrap;
  logic [7:0]        ms_val [NUM_MS];
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap, year_wrap;
  logic date_step;

  assign ms_step[0] = tick_1hz;

  // seconds and minutes share one shape
  for (genvar i = 0; i < NUM_MS; i++) begin : g_ms
    rtc_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .KEEP_MASK(8'h00)) u_f (
      .clk(clk), .rst_n(rst_n), .step(ms_step[i]), .load(ld[i]),
      .load_val(wr_data), .top_val(8'h59),
      .value(ms_val[i]), .wrap(ms_wrap[i])
    );
    assign ms_step[i+1] = ms_wrap[i];
  end

  assign sec_o    = ms_val[0];
  assign min_o    = ms_val[1];
  assign sec_wrap = ms_wrap[0];
  assign min_wrap = ms_wrap[1];

  rtc_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .KEEP_MASK(8'hC0)) u_hour (
    .clk(clk), .rst_n(rst_n), .step(min_wrap), .load(ld[F_HOUR]),
    .load_val(wr_data), .top_val(8'h23), .value(hour_o), .wrap(hour_wrap)
  );

  assign date_step = hour_wrap;

  logic [7:0] date_top;
  assign date_top = last_day(month_o, year_o);

  rtc_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(8'h01), .KEEP_MASK(8'h00)) u_date (
    .clk(clk), .rst_n(rst_n), .step(date_step), .load(ld[F_DATE]),
    .load_val(wr_data), .top_val(date_top), .value(date_o), .wrap(date_wrap)
  );

  rtc_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(8'h01), .KEEP_MASK(8'h00)) u_month (
    .clk(clk), .rst_n(rst_n), .step(date_wrap), .load(ld[F_MONTH]),
    .load_val(wr_data), .top_val(8'h12), .value(month_o), .wrap(month_wrap)
  );

  rtc_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .KEEP_MASK(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .step(month_wrap), .load(ld[F_YEAR]),
    .load_val(wr_data), .top_val(8'h99), .value(year_o), .wrap(year_wrap)
  );

  rtc_dow #(.DAYS(DOW_DAYS)) u_dow (
    .clk(clk), .rst_n(rst_n), .step(date_step), .load(ld[F_DOW]),
    .load_val(wr_data), .value(dow_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                               cent_o <= 8'h20;
    else if (ld[F_CENT])                      cent_o <= wr_data;
    else if (year_wrap && cent_o == CENT_OLD) cent_o <= CENT_NEW;
  end

  // ---------------- assertions ----------------
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1hz && !wr_en |=> $stable({sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o, cent_o}));

  p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_wrap && !(wr_en && sel == F_MIN) |=> $stable(min_o));

  p_date_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    date_o != 8'h00);

  p_month_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    month_o != 8'h00 && month_o <= 8'h12);

  p_dow_follows_date_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !date_step && !(wr_en && sel == F_DOW) |=> $stable(dow_o));

  p_cent_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap && cent_o == CENT_OLD && !(wr_en && sel == F_CENT) |=> cent_o == CENT_NEW);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel == F_SEC |=> sec_o == $past(wr_data));

endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_field = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o, cent_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_field(wr_field), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .dow_o(dow_o), .cent_o(cent_o)
  );

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // independent model in plain integers
  int s = 0, m = 0, h = 0, d = 1, mo = 1, y = 0, dw = 0, cen = 20;
  bit hmode = 0;

  function automatic int bcd2bin(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int month_days(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] model_pack();
    return {bin2bcd(cen), bin2bcd(y), bin2bcd(mo), bin2bcd(d),
            8'(dw), {hmode, 1'b0, bin2bcd(h)[5:0]}, bin2bcd(m), bin2bcd(s)};
  endfunction

  task automatic model_tick();
    s++;
    if (s < 60) return;
    s = 0; m++;
    if (m < 60) return;
    m = 0; h++;
    if (h < 24) return;
    h = 0;
    dw = (dw + 1) % 7;
    d++;
    if (d <= month_days(mo, y)) return;
    d = 1; mo++;
    if (mo <= 12) return;
    mo = 1; y++;
    if (y <= 99) return;
    y = 0;
    if (cen == 19) cen = 20;
  endtask

  task automatic model_write(input logic [2:0] f, input logic [7:0] v);
    case (f)
      3'd0: s = bcd2bin(v);
      3'd1: m = bcd2bin(v);
      3'd2: begin hmode = v[7]; h = bcd2bin({2'b00, v[5:0]}); end
      3'd3: d = bcd2bin(v);
      3'd4: mo = bcd2bin(v);
      3'd5: y = bcd2bin(v);
      3'd6: dw = int'(v[2:0]);
      default: cen = bcd2bin(v);
    endcase
  endtask

  // driver: one cycle of stimulus, then push what the outputs must show
  task automatic cyc(input bit t, input bit w, input logic [2:0] f,
                     input logic [7:0] v, input string tag);
    item_t it;
    @(negedge clk);
    tick_1hz = t; wr_en = w; wr_field = f; wr_data = v;
    @(posedge clk);
    if (t) model_tick();
    if (w) model_write(f, v);
    it.exp = model_pack();
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] f, input logic [7:0] v);
    cyc(0, 1, f, v, "R9 write");
  endtask

  task automatic set_time(input logic [7:0] yy, input logic [7:0] mm, input logic [7:0] dd,
                          input logic [7:0] hh, input logic [7:0] mi, input logic [7:0] ss);
    wr(3'd5, yy); wr(3'd4, mm); wr(3'd3, dd);
    wr(3'd2, hh); wr(3'd1, mi); wr(3'd0, ss);
  endtask

  // monitor: compare each pushed expectation half a cycle after its edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      act = {cent_o, year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, "R1 R10 reset values");

    // R2 R3: seconds through their wrap into minutes
    for (int i = 0; i < 65; i++) cyc(1, 0, 0, 0, "R2 R3 seconds count");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R2 hold without tick");

    // R3: minute and hour carry with mode flag kept
    set_time(8'h23, 8'h03, 8'h14, 8'h80 | 8'h09, 8'h59, 8'h58);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R3 hour carry, flag kept");

    // R6 R7 R8: end of century
    wr(3'd7, 8'h19); wr(3'd6, 8'h06);
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R6 R7 R8 century step");

    // R8: century already 20 stays 20
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0, "R8 century 20 holds");

    // R5: February in common and leap years
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0, "R5 Feb 28 common year");
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0, "R5 Feb 29 leap year");
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    cyc(1, 0, 0, 0, "R5 Feb 29 to Mar 1");
    set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0, "R5 year 00 is leap");
    set_time(8'h10, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0, "R5 year 10 common");

    // R4: 30 and 31 day months
    set_time(8'h25, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0, "R4 Apr 30 wraps");
    set_time(8'h25, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0, "R4 Nov 30 wraps");
    set_time(8'h25, 8'h07, 8'h30, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0, "R4 Jul 30 to 31");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R2 R4 after date step");

    // R9: write beats tick on its field, carry from old value still moves
    wr(3'd0, 8'h59);
    cyc(1, 1, 3'd0, 8'h10, "R9 write wins over tick");
    cyc(1, 1, 3'd1, 8'h42, "R9 write minutes during tick");
    cyc(1, 0, 0, 0, "R9 after write");

    @(negedge clk);
    tick_1hz = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule